// File: doc/BRIEF.md
# Transmit Segment Scheduler with Completion Ring

This block sits between a host processor and a downstream packet engine. Software asks for a transmit by making two register writes. The first write stores the start address of a memory buffer. The second write gives the length and the target endpoint, and it is this second write that queues the request. The block keeps a small queue of outstanding segments for each of four endpoints. It offers the segment at the head of each queue to the packet engine through a valid/ready handshake, picking between the endpoints in round-robin order.

When the packet engine reports that a segment is finished, the block frees that slot in the queue. It also writes a completion record into a small ring that software drains. Software reads the record under its read pointer, then writes the pointer forward. A general status flag shows whether any record is still unread. For a short guard time after each accepted command, the block shows a busy flag and ignores further commands.

Register map (byte offsets on `reg_addr`):

- 0x40: command. A write queues a command. A read returns busy in bit 16.
- 0x44: buffer start address.
- 0x48: per-endpoint status.
- 0x4C: general status.
- 0x70: ring write pointer.
- 0x74: ring record under the read pointer.
- 0x78: ring read pointer.

Top module: `tx_cmd_sched`

## Requirements
- R1: A write to 0x44 stores the buffer start address. A write to 0x40 queues a segment with that stored address. The segment size is taken from bits 15:0 of the 0x40 write. The endpoint code is taken from bits 31:29, where 000, 001, 010 and 011 select endpoints 0 to 3. The same code appears on `seg_ep`, on `done_ep` and in the completion records.
- R2: A command whose endpoint code has bit 31 set (codes 100 to 111) is ignored. No pending count changes.
- R3: Each endpoint holds at most two pending segments. A command to an endpoint that already holds two is ignored with no state change.
- R4: An accepted command write makes bit 16 of a 0x40 read equal to 1 for the next two cycles. Any command write that arrives while busy is ignored.
- R5: A size of zero is not discarded. It is queued and offered downstream with `seg_size` = 0 and `seg_zlp` = 1.
- R6: A read of 0x48 returns one 4-bit lane per endpoint, with endpoint i in bits [4i+3:4i]. In each lane, bits 1:0 hold the pending count and bit 2 is 1 when the endpoint holds two segments.
- R7: While `seg_valid` is 1 and `seg_ready` is 0, the offered endpoint, address and size hold stable. Each endpoint has at most one segment in flight downstream, and its segments go out in the order they were queued.
- R8: Endpoints with a segment waiting are served in round-robin order. After reset the search starts at endpoint 0. After a handshake the search starts at the endpoint following the one just served.
- R9: A `done_valid` pulse for an endpoint whose head segment is in flight removes that segment. It also appends a record to the ring: the endpoint code in bits 31:29 and the size in bits 15:0. The record is readable at 0x74. A pulse for an endpoint with nothing in flight is ignored.
- R10: The ring holds four records. A read of 0x70 returns a 3-bit wrapping write pointer, and 0x78 holds a 3-bit read pointer that software can write. While four records are unread, a new completion still frees its queue slot, but no record is written.
- R11: Bit 0 of a 0x4C read is 1 exactly when the write pointer differs from the read pointer.
- R12: A completion and an accepted command for the same endpoint in the same cycle both take effect. The count stays unchanged and the new segment is queued.
- R13: After reset, every count, pointer and flag is zero and `seg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, a combinational function of `reg_addr` |
| seg_valid | output | 1 | A segment is offered downstream |
| seg_ready | input | 1 | The downstream engine accepts the offered segment |
| seg_ep | output | 3 | Endpoint code of the offered segment |
| seg_addr | output | ADDR_W | Buffer start address of the offered segment |
| seg_size | output | SIZE_W | Size of the offered segment |
| seg_zlp | output | 1 | The offered segment is a zero-length packet |
| done_valid | input | 1 | Completion pulse from downstream |
| done_ep | input | 3 | Endpoint code of the completion |

## Verification
The sharpest case is a completion and a new command for the same endpoint landing in the same clock edge. The bench provokes it by raising `done_valid` for endpoint 3 in the very cycle in which its command write to 0x40 is sampled. It then checks three things. The pending lane still reads 1. The completion record for the old segment is present. The next segment offered for endpoint 3 carries the new address and size. A second collision is also tested: a completion that arrives while the ring is full. The bench checks that the queue slot is freed while the write pointer does not move.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    localparam int EP_N     = 4;
    localparam int REG_W    = 32;
    localparam int BUSY_BIT = 16;

    localparam logic [7:0] OFS_CMD    = 8'h40;
    localparam logic [7:0] OFS_CADDR  = 8'h44;
    localparam logic [7:0] OFS_EPSTAT = 8'h48;
    localparam logic [7:0] OFS_GSTAT  = 8'h4C;
    localparam logic [7:0] OFS_MBWP   = 8'h70;
    localparam logic [7:0] OFS_MBDATA = 8'h74;
    localparam logic [7:0] OFS_MBRP   = 8'h78;

    typedef logic [2:0] ep_code_t;

    // Codes with the top bit set name no endpoint.
    function automatic logic ep_code_ok(ep_code_t c);
        return c[2] == 1'b0;
    endfunction
endpackage

// File: rtl/tcs_ep_queue.sv
module tcs_ep_queue #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [ADDR_W-1:0]           push_addr_i,
    input  logic [SIZE_W-1:0]           push_size_i,
    input  logic                        issue_i,
    input  logic                        pop_i,
    output logic [$clog2(DEPTH+1)-1:0]  cnt_o,
    output logic                        full_o,
    output logic                        req_o,
    output logic                        inflight_o,
    output logic [ADDR_W-1:0]           head_addr_o,
    output logic [SIZE_W-1:0]           head_size_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [CW-1:0]                  cnt;
        logic [IW-1:0]                  hd;
        logic                           issued;
        logic [DEPTH-1:0][ADDR_W-1:0]   addr;
        logic [DEPTH-1:0][SIZE_W-1:0]   size;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  push_ok, pop_ok;
    logic [IW-1:0] wr_slot;

    always_comb begin
        st_d    = st_q;
        push_ok = push_i && (st_q.cnt < CW'(DEPTH));
        pop_ok  = pop_i && st_q.issued;
        wr_slot = st_q.hd + st_q.cnt[IW-1:0];
        if (push_ok) begin
            st_d.addr[wr_slot] = push_addr_i;
            st_d.size[wr_slot] = push_size_i;
        end
        if (issue_i) begin
            st_d.issued = 1'b1;
        end
        if (pop_ok) begin
            st_d.hd     = st_q.hd + IW'(1);
            st_d.issued = 1'b0;
        end
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o       = st_q.cnt;
    assign full_o      = (st_q.cnt == CW'(DEPTH));
    assign req_o       = (st_q.cnt != '0) && !st_q.issued;
    assign inflight_o  = st_q.issued;
    assign head_addr_o = st_q.addr[st_q.hd];
    assign head_size_o = st_q.size[st_q.hd];
endmodule

// File: rtl/tcs_rr_arb.sv
module tcs_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    input  logic                 accept_i,
    output logic                 any_o,
    output logic [$clog2(N)-1:0] gnt_o
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] rr;
        logic          held;
        logic [IW-1:0] hidx;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic [IW-1:0] pick, cand;
    logic          found;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        pick  = '0;
        cand  = '0;
        if (st_q.held) begin
            pick  = st_q.hidx;
            found = req_i[st_q.hidx];
        end else begin
            for (int k = 0; k < N; k++) begin
                cand = st_q.rr + IW'(k);
                if (!found && req_i[cand]) begin
                    found = 1'b1;
                    pick  = cand;
                end
            end
        end
        if (found && accept_i) begin
            st_d.rr   = pick + IW'(1);
            st_d.held = 1'b0;
        end else if (found) begin
            st_d.held = 1'b1;
            st_d.hidx = pick;
        end else begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_o = found;
    assign gnt_o = pick;
endmodule

// File: rtl/tcs_cpl_ring.sv
module tcs_cpl_ring #(
    parameter int DEPTH  = 4,
    parameter int SIZE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [2:0]                 push_code_i,
    input  logic [SIZE_W-1:0]          push_size_i,
    input  logic                       rp_we_i,
    input  logic [$clog2(DEPTH):0]     rp_wdata_i,
    output logic [$clog2(DEPTH):0]     wp_o,
    output logic [$clog2(DEPTH):0]     rp_o,
    output logic [2:0]                 rd_code_o,
    output logic [SIZE_W-1:0]          rd_size_o,
    output logic                       unread_o
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam int EW = 3 + SIZE_W;

    typedef struct packed {
        logic [PW-1:0]              wp;
        logic [PW-1:0]              rp;
        logic [DEPTH-1:0][EW-1:0]   mem;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic     full;
    logic [EW-1:0] rd_ent;

    always_comb begin
        st_d = st_q;
        full = ((st_q.wp - st_q.rp) == PW'(DEPTH));
        if (push_i && !full) begin
            st_d.mem[st_q.wp[PW-2:0]] = {push_code_i, push_size_i};
            st_d.wp = st_q.wp + PW'(1);
        end
        if (rp_we_i) begin
            st_d.rp = rp_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ent    = st_q.mem[st_q.rp[PW-2:0]];
    assign rd_code_o = rd_ent[EW-1 -: 3];
    assign rd_size_o = rd_ent[SIZE_W-1:0];
    assign wp_o      = st_q.wp;
    assign rp_o      = st_q.rp;
    assign unread_o  = (st_q.wp != st_q.rp);
endmodule

// File: rtl/tx_cmd_sched.sv
module tx_cmd_sched
    import tcs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 16,
    parameter int SEG_DEPTH  = 2,
    parameter int MBOX_DEPTH = 4,
    parameter int BUSY_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [2:0]        seg_ep,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [SIZE_W-1:0] seg_size,
    output logic              seg_zlp,
    input  logic              done_valid,
    input  logic [2:0]        done_ep
);
    localparam int CW = $clog2(SEG_DEPTH + 1);
    localparam int EW = $clog2(EP_N);
    localparam int PW = $clog2(MBOX_DEPTH) + 1;
    localparam int BW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] caddr;
        logic [BW-1:0]     busy_cnt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                     busy, cmd_wr, cmd_ok, done_ok;
    ep_code_t                 cmd_code;
    logic [EP_N-1:0]          push_v, issue_v, pop_v, req_v, full_v, infl_v;
    logic [EP_N*CW-1:0]       cnt_flat;
    logic [ADDR_W-1:0]        hd_addr [EP_N];
    logic [SIZE_W-1:0]        hd_size [EP_N];
    logic                     arb_any;
    logic [EW-1:0]            arb_gnt;
    logic                     ring_push, rp_we;
    logic [PW-1:0]            ring_wp, ring_rp;
    logic [2:0]               ring_code;
    logic [SIZE_W-1:0]        ring_size;
    logic                     ring_unread;

    assign busy     = (st_q.busy_cnt != '0);
    assign cmd_wr   = reg_wr && (reg_addr == OFS_CMD);
    assign cmd_ok   = cmd_wr && !busy;
    assign cmd_code = reg_wdata[31:29];
    assign done_ok  = done_valid && ep_code_ok(done_ep);
    assign rp_we    = reg_wr && (reg_addr == OFS_MBRP);

    always_comb begin
        st_d = st_q;
        if (reg_wr && (reg_addr == OFS_CADDR)) begin
            st_d.caddr = reg_wdata[ADDR_W-1:0];
        end
        if (cmd_ok)    st_d.busy_cnt = BW'(BUSY_CYC);
        else if (busy) st_d.busy_cnt = st_q.busy_cnt - BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar i = 0; i < EP_N; i++) begin : g_ep
            assign push_v[i]  = cmd_ok && ep_code_ok(cmd_code) && (cmd_code[EW-1:0] == EW'(i));
            assign issue_v[i] = arb_any && seg_ready && (arb_gnt == EW'(i));
            assign pop_v[i]   = done_ok && (done_ep[EW-1:0] == EW'(i));

            tcs_ep_queue #(
                .ADDR_W (ADDR_W),
                .SIZE_W (SIZE_W),
                .DEPTH  (SEG_DEPTH)
            ) u_q (
                .clk         (clk),
                .rst_n       (rst_n),
                .push_i      (push_v[i]),
                .push_addr_i (st_q.caddr),
                .push_size_i (reg_wdata[SIZE_W-1:0]),
                .issue_i     (issue_v[i]),
                .pop_i       (pop_v[i]),
                .cnt_o       (cnt_flat[i*CW +: CW]),
                .full_o      (full_v[i]),
                .req_o       (req_v[i]),
                .inflight_o  (infl_v[i]),
                .head_addr_o (hd_addr[i]),
                .head_size_o (hd_size[i])
            );
        end
    endgenerate

    tcs_rr_arb #(.N(EP_N)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_v),
        .accept_i (seg_ready),
        .any_o    (arb_any),
        .gnt_o    (arb_gnt)
    );

    assign ring_push = done_ok && infl_v[done_ep[EW-1:0]];

    tcs_cpl_ring #(
        .DEPTH  (MBOX_DEPTH),
        .SIZE_W (SIZE_W)
    ) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ring_push),
        .push_code_i (done_ep),
        .push_size_i (hd_size[done_ep[EW-1:0]]),
        .rp_we_i     (rp_we),
        .rp_wdata_i  (reg_wdata[PW-1:0]),
        .wp_o        (ring_wp),
        .rp_o        (ring_rp),
        .rd_code_o   (ring_code),
        .rd_size_o   (ring_size),
        .unread_o    (ring_unread)
    );

    assign seg_valid = arb_any;
    assign seg_ep    = 3'(arb_gnt);
    assign seg_addr  = hd_addr[arb_gnt];
    assign seg_size  = hd_size[arb_gnt];
    assign seg_zlp   = arb_any && (hd_size[arb_gnt] == '0);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:    reg_rdata[BUSY_BIT] = busy;
            OFS_CADDR:  reg_rdata[ADDR_W-1:0] = st_q.caddr;
            OFS_EPSTAT: begin
                for (int i = 0; i < EP_N; i++) begin
                    reg_rdata[4*i +: 4] = {1'b0, full_v[i], 2'(cnt_flat[i*CW +: CW])};
                end
            end
            OFS_GSTAT:  reg_rdata[0] = ring_unread;
            OFS_MBWP:   reg_rdata[PW-1:0] = ring_wp;
            OFS_MBDATA: begin
                reg_rdata[31:29]       = ring_code;
                reg_rdata[SIZE_W-1:0]  = ring_size;
            end
            OFS_MBRP:   reg_rdata[PW-1:0] = ring_rp;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 16,
    parameter int SEG_DEPTH = 2,
    parameter int EP_N      = 4,
    parameter int CW        = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [2:0]        seg_ep,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [SIZE_W-1:0] seg_size,
    input logic              done_valid,
    input logic              busy,
    input logic [EP_N*CW-1:0] cnt_flat
);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_ep) && $stable(seg_addr) && $stable(seg_size));

    // R4
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 8'h40) && !busy |=> busy);

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 8'h40) && busy && !done_valid |=> $stable(cnt_flat));

    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 8'h40) && reg_wdata[31] && !done_valid |=> $stable(cnt_flat));

    generate
        for (genvar i = 0; i < EP_N; i++) begin : g_cap
            // R3
            depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_flat[i*CW +: CW] <= CW'(SEG_DEPTH));
        end
    endgenerate
endmodule

bind tx_cmd_sched tcs_chk #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .SEG_DEPTH (SEG_DEPTH),
    .EP_N      (tcs_pkg::EP_N),
    .CW        ($clog2(SEG_DEPTH + 1))
) u_tcs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_ep     (seg_ep),
    .seg_addr   (seg_addr),
    .seg_size   (seg_size),
    .done_valid (done_valid),
    .busy       (busy),
    .cnt_flat   (cnt_flat)
);

// File: tb/test_tx_cmd_sched.sv
module test_tx_cmd_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seg_valid, seg_zlp;
    logic        seg_ready = 1'b0;
    logic [2:0]  seg_ep;
    logic [31:0] seg_addr;
    logic [15:0] seg_size;
    logic        done_valid = 1'b0;
    logic [2:0]  done_ep = 3'd0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tx_cmd_sched i_tx_cmd_sched (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_valid(seg_valid),
        .seg_ready(seg_ready), .seg_ep(seg_ep), .seg_addr(seg_addr),
        .seg_size(seg_size), .seg_zlp(seg_zlp), .done_valid(done_valid),
        .done_ep(done_ep)
    );

    // Handshake log: values sampled after inputs settle, transfer at next edge.
    logic [2:0]  log_ep   [16];
    logic [31:0] log_addr [16];
    logic [15:0] log_size [16];
    logic        log_zlp  [16];
    int          log_n = 0;

    always @(negedge clk) begin
        #1;
        if (seg_valid && seg_ready && log_n < 16) begin
            log_ep[log_n]   = seg_ep;
            log_addr[log_n] = seg_addr;
            log_size[log_n] = seg_size;
            log_zlp[log_n]  = seg_zlp;
            log_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cmd(input logic [2:0] code, input logic [15:0] sz, input logic [31:0] adr);
        wr(8'h44, adr);
        wr(8'h40, {code, 13'd0, sz});
        repeat (2) @(negedge clk);
    endtask

    task automatic done(input logic [2:0] code);
        @(negedge clk);
        done_valid = 1'b1; done_ep = code;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
    endtask

    // {code, size, address, expected 0x48}
    localparam logic [82:0] VEC [7] = '{
        {3'd0, 16'd64,  32'h0000_1000, 32'h0000_0001},  // R1
        {3'd2, 16'd0,   32'h0000_2000, 32'h0000_0101},  // R5 queued
        {3'd0, 16'd8,   32'h0000_3000, 32'h0000_0106},  // R6 full flag
        {3'd0, 16'd12,  32'h0000_4000, 32'h0000_0106},  // R3 third dropped
        {3'd5, 16'd9,   32'h0000_5000, 32'h0000_0106},  // R2 bad code
        {3'd3, 16'd4,   32'h0000_6000, 32'h0000_1106},  // R6
        {3'd1, 16'd100, 32'h0000_7000, 32'h0000_1116}   // R6
    };

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        rd(8'h48, r); check("R13 status", r, 32'h0);
        rd(8'h4C, r); check("R13 unread", r, 32'h0);
        rd(8'h70, r); check("R13 wp", r, 32'h0);
        rd(8'h40, r); check("R13 busy", r, 32'h0);
        check("R13 seg_valid", {31'd0, seg_valid}, 32'h0);

        for (int v = 0; v < 7; v++) begin
            cmd(VEC[v][82:80], VEC[v][79:64], VEC[v][63:32]);
            rd(8'h48, r);
            check($sformatf("R1/R2/R3/R6 vector %0d", v), r, VEC[v][31:0]);
        end

        // R7 offer held while not ready
        check("R7 held valid", {31'd0, seg_valid}, 32'h1);
        check("R7 held ep", {29'd0, seg_ep}, 32'h0);
        check("R7 held addr", seg_addr, 32'h1000);

        @(negedge clk); seg_ready = 1'b1;
        repeat (6) @(negedge clk);
        // R8 round robin order, R5 zlp
        check("R8 count", log_n, 4);
        check("R8 first ep", {29'd0, log_ep[0]}, 32'd0);
        check("R8 second ep", {29'd0, log_ep[1]}, 32'd1);
        check("R8 third ep", {29'd0, log_ep[2]}, 32'd2);
        check("R8 fourth ep", {29'd0, log_ep[3]}, 32'd3);
        check("R1 addr ep1", log_addr[1], 32'h7000);
        check("R1 size ep1", {16'd0, log_size[1]}, 32'd100);
        check("R5 zlp size", {16'd0, log_size[2]}, 32'd0);
        check("R5 zlp flag", {31'd0, log_zlp[2]}, 32'd1);
        check("R5 no zlp on nonzero", {31'd0, log_zlp[3]}, 32'd0);

        // R9 completion
        done(3'd0);
        rd(8'h74, r); check("R9 record", r, 32'h0000_0040);
        rd(8'h70, r); check("R10 wp after one", r, 32'd1);
        rd(8'h4C, r); check("R11 unread set", r, 32'd1);
        repeat (3) @(negedge clk);
        check("R7 fifo order ep0", log_addr[4], 32'h3000);
        rd(8'h48, r); check("R9 count dec", r, 32'h0000_1111);

        // R12 completion and command on ep3 in the same cycle
        wr(8'h44, 32'h8000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = {3'd3, 13'd0, 16'd20};
        done_valid = 1'b1; done_ep = 3'd3;
        @(negedge clk);
        reg_wr = 1'b0; done_valid = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h48, r); check("R12 ep3 count", r, 32'h0000_1111);
        rd(8'h70, r); check("R12 record written", r, 32'd2);
        check("R12 new seg addr", log_addr[5], 32'h8000);
        check("R12 new seg size", {16'd0, log_size[5]}, 32'd20);

        // R10 ring full
        done(3'd1);
        done(3'd2);
        rd(8'h70, r); check("R10 wp four", r, 32'd4);
        done(3'd0);
        rd(8'h70, r); check("R10 full drop", r, 32'd4);
        rd(8'h48, r); check("R10 slot freed", r, 32'h0000_1000);

        // R9 stray completion ignored
        done(3'd1);
        rd(8'h48, r); check("R9 stray status", r, 32'h0000_1000);
        rd(8'h70, r); check("R9 stray wp", r, 32'd4);

        // R10/R11 drain
        wr(8'h78, 32'd1);
        rd(8'h74, r); check("R9 record ep3", r, 32'h6000_0004);
        rd(8'h4C, r); check("R11 still unread", r, 32'd1);
        wr(8'h78, 32'd4);
        rd(8'h4C, r); check("R11 cleared", r, 32'd0);

        // R4 busy window
        wr(8'h44, 32'h9000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = {3'd1, 13'd0, 16'd7};
        @(negedge clk);
        reg_wdata = {3'd1, 13'd0, 16'd9};
        #1 check("R4 busy high", reg_rdata, 32'h0001_0000);
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h40, r); check("R4 busy low", r, 32'h0);
        rd(8'h48, r); check("R4 second dropped", r, 32'h0000_1010);
        check("R4 issued count", log_n, 7);
        check("R4 issued size", {16'd0, log_size[6]}, 32'd7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule